// File: doc/BRIEF.md
# Register Move and Swap Eliminator

This rename-stage block decides, one request per clock, whether a register copy (one source, one destination) or an exchange (two sources, two destinations) can be retired by pointer aliasing instead of being sent to an execution unit. It keeps two small tables indexed by wide register: an alias pointer and a known-zero bit. It also keeps a per-file count of the eliminations granted in the current rename group, checked against a per-file budget.

Register IDs are `IDW` bits wide. When the top bit is clear, the ID names a wide register whose index is the low `IDW-1` bits. When it is set, the ID names the narrow lower part of that same wide register. Canonical index 0 is reserved as invalid, and an alias value of 0 means "no alias". File membership, the per-class permission to eliminate, the zero-only mode and the budgets are parameters. A separate port reports ordinary, non-eliminated writes so that the tables stay current. A lookup port reads back one table entry.

Top module: `mv_swap_elim`

## Requirements
- R1: A request is eligible only if it has equal read and write counts and that count is 1 (copy) or 2 (exchange). Counts of 0 or 3, or unequal counts, are rejected.
- R2: In an exchange, destination j takes its value from source 1-j: write 0 pairs with read 1, and write 1 pairs with read 0.
- R3: `grp_start` high with a request zeroes every file's counter before that request is judged. A file with a nonzero budget rejects a request whose count plus the number of pairs would exceed the budget. A budget of 0 means no limit. Each grant adds its pair count to the file of write 0.
- R4: Every source and destination must lie in the same file as write 0. Each destination's wide class must have its `MOVE_OK` bit set.
- R5: A destination with the narrow bit set is rejected unless its `wr_clr` bit marks the write as clearing the upper part.
- R6: In a file whose `ZERO_ONLY` bit is set, a pair is granted only if its source is currently known zero.
- R7: All pairs are checked against the state as it stood before the request. Either every pair is granted and updated, or nothing changes.
- R8: A granted destination's alias becomes the source's alias if the source has one, and the source's own wide index otherwise. If that target equals the destination itself, the alias is stored as 0.
- R9: `wzero_o[j]` is 1 exactly when write j was granted and its source was known zero. The destination's known-zero bit takes the source's value.
- R10: An ordinary write clears the alias of its wide register, which also covers the narrow part. It sets the known-zero bit only for a zero write that is wide or clears the upper part, and clears the bit otherwise. When both touch the same entry in one clock, the ordinary write wins over a grant.
- R11: A source or destination whose canonical index is 0 is always rejected.
- R12: `elim_o` and `wzero_o` report the request sampled at the previous clock edge. The lookup outputs show the table contents as they stood at the previous edge. Reset clears all outputs, tables and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_start | input | 1 | First request of a rename group; zeroes the budget counters |
| req_valid | input | 1 | Elimination request present |
| rd_cnt | input | 2 | Number of register reads in the request |
| wr_cnt | input | 2 | Number of register writes in the request |
| rd_id0 | input | IDW | Read operand 0 |
| rd_id1 | input | IDW | Read operand 1 |
| wr_id0 | input | IDW | Write operand 0 |
| wr_id1 | input | IDW | Write operand 1 |
| wr_clr | input | 2 | Per write: clears the upper part of the wide register |
| nw_valid | input | 1 | Ordinary (non-eliminated) write present |
| nw_id | input | IDW | Destination of the ordinary write |
| nw_zero | input | 1 | Ordinary write produces zero |
| nw_clr | input | 1 | Ordinary write clears the upper part |
| look_id | input | IDW | Register to read back |
| elim_o | output | 1 | Previous request was eliminated |
| wzero_o | output | 2 | Per write: eliminated with a known-zero source |
| look_alias_o | output | IDW | Alias entry of `look_id` (0 = none) |
| look_zero_o | output | 1 | Known-zero bit of `look_id` |

## Verification
The properties assume that `grp_start` is raised only together with a request. They also assume that the two destinations of an exchange name different wide registers, because the block does not arbitrate two grants aimed at one entry. The directed stimulus follows both rules: every exchange it issues targets distinct registers, and group starts always ride on a request. Request fields are held at known values in every cycle, including idle ones, so that the past-value checks never see unknowns.

// File: rtl/mse_pkg.sv
package mse_pkg;

  typedef enum logic [1:0] {
    SHAPE_BAD  = 2'd0,
    SHAPE_MOVE = 2'd1,
    SHAPE_SWAP = 2'd2
  } shape_e;

  function automatic shape_e classify(input logic [1:0] nr, input logic [1:0] nw);
    if (nr != nw) return SHAPE_BAD;
    if (nr == 2'd1) return SHAPE_MOVE;
    if (nr == 2'd2) return SHAPE_SWAP;
    return SHAPE_BAD;
  endfunction

endpackage

// File: rtl/mse_budget.sv
module mse_budget #(
  parameter int FSEL_W = 1,
  parameter int CW     = 3,
  parameter logic [(1<<FSEL_W)*CW-1:0] LIMITS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_start,
  input  logic              commit,
  input  logic [FSEL_W-1:0] req_file,
  input  logic [1:0]        req_n,
  output logic              fits
);
  localparam int FILES = 1 << FSEL_W;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q [FILES];
  logic [CW-1:0] eff, lim;
  logic [CW:0]   sum;

  always_comb begin
    eff  = grp_start ? '0 : cnt_q[req_file];
    lim  = LIMITS[req_file*CW +: CW];
    sum  = {1'b0, eff} + {{(CW-1){1'b0}}, req_n};
    fits = (lim == '0) || (sum <= {1'b0, lim});
  end

  always_ff @(posedge clk) begin
    for (int f = 0; f < FILES; f++) begin
      if (rst)
        cnt_q[f] <= '0;
      else if (commit && req_file == FSEL_W'(f))
        cnt_q[f] <= sum[CW] ? CMAX : sum[CW-1:0];
      else if (grp_start)
        cnt_q[f] <= '0;
    end
  end
endmodule

// File: rtl/mse_tables.sv
module mse_tables #(
  parameter int HW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             upd_en,
  input  logic [1:0][HW-1:0]     upd_idx,
  input  logic [1:0][HW-1:0]     upd_tgt,
  input  logic [1:0]             upd_zero,
  input  logic                   nw_en,
  input  logic [HW-1:0]          nw_idx,
  input  logic                   nw_zero,
  input  logic [HW-1:0]          look_idx,
  output logic [(1<<HW)*HW-1:0]  alias_flat,
  output logic [(1<<HW)-1:0]     zero_vec,
  output logic [HW-1:0]          look_tgt,
  output logic                   look_zero
);
  localparam int ENTRIES = 1 << HW;

  logic [HW-1:0]      alias_q [ENTRIES];
  logic [ENTRIES-1:0] zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) alias_q[e] <= '0;
      zero_q    <= '0;
      look_tgt  <= '0;
      look_zero <= 1'b0;
    end else begin
      look_tgt  <= alias_q[look_idx];
      look_zero <= zero_q[look_idx];
      for (int e = 0; e < ENTRIES; e++) begin
        if (nw_en && nw_idx == HW'(e)) begin
          alias_q[e] <= '0;
          zero_q[e]  <= nw_zero;
        end else if (upd_en[1] && upd_idx[1] == HW'(e)) begin
          alias_q[e] <= upd_tgt[1];
          zero_q[e]  <= upd_zero[1];
        end else if (upd_en[0] && upd_idx[0] == HW'(e)) begin
          alias_q[e] <= upd_tgt[0];
          zero_q[e]  <= upd_zero[0];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
      assign alias_flat[g*HW +: HW] = alias_q[g];
    end
  endgenerate
  assign zero_vec = zero_q;
endmodule

// File: rtl/mse_decide.sv
module mse_decide
  import mse_pkg::*;
#(
  parameter int IDW    = 4,
  parameter int FSEL_W = 1,
  parameter logic [(1<<(IDW-1))*FSEL_W-1:0] FILE_MAP  = '0,
  parameter logic [(1<<(IDW-1))-1:0]        MOVE_OK   = '1,
  parameter logic [(1<<FSEL_W)-1:0]         ZERO_ONLY = '0
) (
  input  logic                          req_valid,
  input  logic [1:0]                    rd_cnt,
  input  logic [1:0]                    wr_cnt,
  input  logic [IDW-1:0]                rd_id0,
  input  logic [IDW-1:0]                rd_id1,
  input  logic [IDW-1:0]                wr_id0,
  input  logic [IDW-1:0]                wr_id1,
  input  logic [1:0]                    wr_clr,
  input  logic [(1<<(IDW-1))*(IDW-1)-1:0] alias_flat,
  input  logic [(1<<(IDW-1))-1:0]       zero_vec,
  input  logic                          fits,
  output logic                          ok,
  output logic [FSEL_W-1:0]             file,
  output logic [1:0]                    npairs,
  output logic [1:0][IDW-2:0]           dst_c,
  output logic [1:0][IDW-2:0]           new_tgt,
  output logic [1:0]                    wz
);
  localparam int HW = IDW - 1;

  shape_e     shape;
  logic [1:0] pass;

  assign shape  = classify(rd_cnt, wr_cnt);
  assign npairs = (shape == SHAPE_SWAP) ? 2'd2 : 2'd1;
  assign file   = FILE_MAP[wr_id0[HW-1:0]*FSEL_W +: FSEL_W];

  generate
    for (genvar j = 0; j < 2; j++) begin : g_pair
      logic [IDW-1:0] src, dst;
      logic [HW-1:0]  sc, dc, a, t;
      logic           active;
      always_comb begin
        if (j == 0) begin
          src    = (shape == SHAPE_SWAP) ? rd_id1 : rd_id0;
          dst    = wr_id0;
          active = (shape != SHAPE_BAD);
        end else begin
          src    = rd_id0;
          dst    = wr_id1;
          active = (shape == SHAPE_SWAP);
        end
        sc = src[HW-1:0];
        dc = dst[HW-1:0];
        a  = alias_flat[sc*HW +: HW];
        t  = (a != '0) ? a : sc;
        new_tgt[j] = (t == dc) ? '0 : t;
        dst_c[j]   = dc;
        wz[j]      = zero_vec[sc];
        pass[j] = !active ||
                  ((sc != '0) && (dc != '0) &&
                   (FILE_MAP[sc*FSEL_W +: FSEL_W] == file) &&
                   (FILE_MAP[dc*FSEL_W +: FSEL_W] == file) &&
                   MOVE_OK[dc] &&
                   !(dst[IDW-1] && !wr_clr[j]) &&
                   (!ZERO_ONLY[file] || zero_vec[sc]));
      end
    end
  endgenerate

  assign ok = req_valid && (shape != SHAPE_BAD) && fits && (&pass);
endmodule

// File: rtl/mv_swap_elim.sv
module mv_swap_elim #(
  parameter int IDW    = 4,
  parameter int FSEL_W = 1,
  parameter int CW     = 3,
  parameter logic [(1<<(IDW-1))*FSEL_W-1:0] FILE_MAP  = 8'b1100_0000,
  parameter logic [(1<<(IDW-1))-1:0]        MOVE_OK   = 8'b1101_1111,
  parameter logic [(1<<FSEL_W)-1:0]         ZERO_ONLY = 2'b10,
  parameter logic [(1<<FSEL_W)*CW-1:0]      LIMITS    = {3'd0, 3'd2}
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grp_start,
  input  logic           req_valid,
  input  logic [1:0]     rd_cnt,
  input  logic [1:0]     wr_cnt,
  input  logic [IDW-1:0] rd_id0,
  input  logic [IDW-1:0] rd_id1,
  input  logic [IDW-1:0] wr_id0,
  input  logic [IDW-1:0] wr_id1,
  input  logic [1:0]     wr_clr,
  input  logic           nw_valid,
  input  logic [IDW-1:0] nw_id,
  input  logic           nw_zero,
  input  logic           nw_clr,
  input  logic [IDW-1:0] look_id,
  output logic           elim_o,
  output logic [1:0]     wzero_o,
  output logic [IDW-1:0] look_alias_o,
  output logic           look_zero_o
);
  localparam int HW = IDW - 1;

  logic                       ok, fits, look_z;
  logic [FSEL_W-1:0]          file;
  logic [1:0]                 npairs, wz, upd_en;
  logic [1:0][HW-1:0]         dst_c, new_tgt;
  logic [(1<<HW)*HW-1:0]      alias_flat;
  logic [(1<<HW)-1:0]         zero_vec;
  logic [HW-1:0]              look_t;
  logic                       nw_zero_eff;
  logic                       elim_q;
  logic [1:0]                 wz_q;

  assign upd_en      = ok ? {npairs == 2'd2, 1'b1} : 2'b00;
  assign nw_zero_eff = nw_zero && (!nw_id[IDW-1] || nw_clr);

  mse_decide #(
    .IDW(IDW), .FSEL_W(FSEL_W), .FILE_MAP(FILE_MAP),
    .MOVE_OK(MOVE_OK), .ZERO_ONLY(ZERO_ONLY)
  ) u_decide (
    .req_valid(req_valid), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .rd_id0(rd_id0), .rd_id1(rd_id1), .wr_id0(wr_id0), .wr_id1(wr_id1),
    .wr_clr(wr_clr), .alias_flat(alias_flat), .zero_vec(zero_vec),
    .fits(fits), .ok(ok), .file(file), .npairs(npairs),
    .dst_c(dst_c), .new_tgt(new_tgt), .wz(wz)
  );

  mse_budget #(.FSEL_W(FSEL_W), .CW(CW), .LIMITS(LIMITS)) u_budget (
    .clk(clk), .rst(rst), .grp_start(grp_start), .commit(ok),
    .req_file(file), .req_n(npairs), .fits(fits)
  );

  mse_tables #(.HW(HW)) u_tables (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_idx(dst_c),
    .upd_tgt(new_tgt), .upd_zero(wz), .nw_en(nw_valid),
    .nw_idx(nw_id[HW-1:0]), .nw_zero(nw_zero_eff),
    .look_idx(look_id[HW-1:0]), .alias_flat(alias_flat),
    .zero_vec(zero_vec), .look_tgt(look_t), .look_zero(look_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      elim_q <= 1'b0;
      wz_q   <= 2'b00;
    end else begin
      elim_q <= ok;
      wz_q   <= wz & upd_en;
    end
  end

  assign elim_o       = elim_q;
  assign wzero_o      = wz_q;
  assign look_alias_o = {1'b0, look_t};
  assign look_zero_o  = look_z;
endmodule

// File: rtl/mse_checker.sv
module mse_checker #(
  parameter int IDW    = 4,
  parameter int FSEL_W = 1,
  parameter logic [(1<<(IDW-1))*FSEL_W-1:0] FILE_MAP  = '0,
  parameter logic [(1<<FSEL_W)-1:0]         ZERO_ONLY = '0
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [1:0]     rd_cnt,
  input logic [1:0]     wr_cnt,
  input logic [IDW-1:0] rd_id0,
  input logic [IDW-1:0] wr_id0,
  input logic [1:0]     wr_clr,
  input logic           elim_o,
  input logic [1:0]     wzero_o
);
  localparam int HW = IDW - 1;

  logic [FSEL_W-1:0] f_wr0, f_rd0;
  logic              good_shape, narrow_keep, zonly;
  assign f_wr0       = FILE_MAP[wr_id0[HW-1:0]*FSEL_W +: FSEL_W];
  assign f_rd0       = FILE_MAP[rd_id0[HW-1:0]*FSEL_W +: FSEL_W];
  assign good_shape  = req_valid && (rd_cnt == wr_cnt) && (rd_cnt == 2'd1 || rd_cnt == 2'd2);
  assign narrow_keep = wr_id0[IDW-1] && !wr_clr[0];
  assign zonly       = ZERO_ONLY[f_wr0];

  assert_shape_R1: assert property (@(posedge clk) disable iff (rst)
    elim_o |-> $past(good_shape));
  assert_same_file_R4: assert property (@(posedge clk) disable iff (rst)
    elim_o |-> $past(f_wr0 == f_rd0));
  assert_no_partial_R5: assert property (@(posedge clk) disable iff (rst)
    elim_o |-> !$past(narrow_keep));
  assert_zero_only_R6: assert property (@(posedge clk) disable iff (rst)
    (elim_o && $past(zonly)) |-> wzero_o[0]);
  assert_wzero_needs_elim_R9: assert property (@(posedge clk) disable iff (rst)
    (|wzero_o) |-> elim_o);
  assert_invalid_id_R11: assert property (@(posedge clk) disable iff (rst)
    elim_o |-> ($past(wr_id0[HW-1:0]) != '0 && $past(rd_id0[HW-1:0]) != '0));
endmodule

bind mv_swap_elim mse_checker #(
  .IDW(IDW), .FSEL_W(FSEL_W), .FILE_MAP(FILE_MAP), .ZERO_ONLY(ZERO_ONLY)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rd_cnt(rd_cnt),
  .wr_cnt(wr_cnt), .rd_id0(rd_id0), .wr_id0(wr_id0), .wr_clr(wr_clr),
  .elim_o(elim_o), .wzero_o(wzero_o)
);

// File: tb/mv_swap_elim_bench.sv
`timescale 1ns/1ps
module mv_swap_elim_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       grp_start = 1'b0, req_valid = 1'b0;
  logic [1:0] rd_cnt = '0, wr_cnt = '0, wr_clr = '0;
  logic [3:0] rd_id0 = '0, rd_id1 = '0, wr_id0 = '0, wr_id1 = '0;
  logic       nw_valid = 1'b0, nw_zero = 1'b0, nw_clr = 1'b0;
  logic [3:0] nw_id = '0, look_id = '0;
  logic       elim_o, look_zero_o;
  logic [1:0] wzero_o;
  logic [3:0] look_alias_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mv_swap_elim u_mv_swap_elim (
    .clk(clk), .rst(rst), .grp_start(grp_start), .req_valid(req_valid),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .rd_id0(rd_id0), .rd_id1(rd_id1),
    .wr_id0(wr_id0), .wr_id1(wr_id1), .wr_clr(wr_clr), .nw_valid(nw_valid),
    .nw_id(nw_id), .nw_zero(nw_zero), .nw_clr(nw_clr), .look_id(look_id),
    .elim_o(elim_o), .wzero_o(wzero_o), .look_alias_o(look_alias_o),
    .look_zero_o(look_zero_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // issue one request at a negedge, check the result one edge later
  task automatic req(input bit gs, input int rc, input int wc, input int r0, input int r1,
                     input int w0, input int w1, input int clr, input int exp_el,
                     input int exp_wz, input string tag);
    grp_start = gs; req_valid = 1'b1;
    rd_cnt = 2'(rc); wr_cnt = 2'(wc);
    rd_id0 = 4'(r0); rd_id1 = 4'(r1); wr_id0 = 4'(w0); wr_id1 = 4'(w1);
    wr_clr = 2'(clr);
    @(negedge clk);
    req_valid = 1'b0; grp_start = 1'b0;
    chk({tag, " elim"}, int'(elim_o), exp_el);
    chk({tag, " wzero"}, int'(wzero_o), exp_wz);
  endtask

  task automatic look(input int id, input int ea, input int ez, input string tag);
    look_id = 4'(id);
    @(negedge clk);
    chk({tag, " alias"}, int'(look_alias_o), ea);
    chk({tag, " zero"}, int'(look_zero_o), ez);
  endtask

  task automatic nwr(input int id, input bit z, input bit clr);
    nw_valid = 1'b1; nw_id = 4'(id); nw_zero = z; nw_clr = clr;
    @(negedge clk);
    nw_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 reset elim", int'(elim_o), 0);
    look(3, 0, 0, "R12 reset table");
  endtask

  task automatic t_budget_chain;
    req(1, 1, 1, 2, 0, 3, 0, 0, 1, 0, "R12 copy 2->3");
    look(3, 2, 0, "R12 alias of 3");
    req(0, 1, 1, 3, 0, 4, 0, 0, 1, 0, "R8 copy 3->4");
    look(4, 2, 0, "R8 collapsed chain");
    req(0, 1, 1, 1, 0, 2, 0, 0, 0, 0, "R3 over budget");
    look(2, 0, 0, "R3 no change");
    req(1, 1, 1, 1, 0, 2, 0, 0, 1, 0, "R3 new group");
    look(2, 1, 0, "R3 alias after reset count");
  endtask

  task automatic t_rejects;
    req(1, 1, 2, 1, 0, 3, 0, 0, 0, 0, "R1 unequal counts");
    req(1, 0, 0, 1, 0, 3, 0, 0, 0, 0, "R1 zero counts");
    req(1, 3, 3, 1, 2, 3, 4, 0, 0, 0, "R1 three counts");
    look(3, 2, 0, "R1 table untouched");
    req(1, 1, 1, 1, 0, 5, 0, 0, 0, 0, "R4 class forbids");
    look(5, 0, 0, "R4 dest untouched");
    req(1, 1, 1, 6, 0, 1, 0, 0, 0, 0, "R4 cross file");
    req(1, 1, 1, 0, 0, 1, 0, 0, 0, 0, "R11 source id 0");
    look(1, 0, 0, "R11 dest untouched");
  endtask

  task automatic t_partial;
    req(1, 1, 1, 1, 0, 11, 0, 0, 0, 0, "R5 narrow keeps upper");
    look(11, 2, 0, "R5 alias unchanged");
    req(1, 1, 1, 1, 0, 11, 0, 1, 1, 0, "R5 narrow clears upper");
    look(11, 1, 0, "R5 narrow alias");
    look(3, 1, 0, "R5 wide alias");
  endtask

  task automatic t_plain_write;
    nwr(3, 1'b0, 1'b0);
    look(11, 0, 0, "R10 sub cleared");
    nwr(12, 1'b1, 1'b0);
    look(4, 0, 0, "R10 narrow zero kept unknown");
    nwr(4, 1'b1, 1'b0);
    look(4, 0, 1, "R10 wide zero write");
  endtask

  task automatic t_swap;
    nwr(2, 1'b0, 1'b0);
    req(1, 2, 2, 1, 3, 1, 3, 0, 1, 0, "R2 exchange");
    look(1, 3, 0, "R2 write0 from read1");
    look(3, 1, 0, "R2 write1 from read0");
    req(0, 1, 1, 2, 0, 4, 0, 0, 0, 0, "R3 budget spent by exchange");
    look(4, 0, 1, "R3 dest untouched");
    req(1, 2, 2, 1, 4, 2, 5, 0, 0, 0, "R7 one pair fails");
    look(2, 0, 0, "R7 nothing applied");
    req(1, 1, 1, 3, 0, 1, 0, 0, 1, 0, "R8 self target");
    look(1, 0, 0, "R8 self stored as none");
  endtask

  task automatic t_zero;
    req(1, 1, 1, 7, 0, 6, 0, 0, 0, 0, "R6 source not zero");
    nwr(7, 1'b1, 1'b0);
    req(1, 1, 1, 7, 0, 6, 0, 0, 1, 1, "R6 zero source");
    look(6, 7, 1, "R9 dest marked zero");
    req(0, 1, 1, 7, 0, 14, 0, 1, 1, 1, "R3 unlimited file");
    req(1, 1, 1, 4, 0, 2, 0, 0, 1, 1, "R9 write-zero");
    look(2, 4, 1, "R9 alias and zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_budget_chain();
    t_rejects();
    t_partial();
    t_plain_write();
    t_swap();
    t_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule